// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block sits between the core of a small device and its pads. Every input pin, every output pin and the output-enable of every output pin gets one scan cell. Each cell has two stages: a shift stage that can grab a parallel value or pass a bit to its neighbour, and an update latch that holds a value stable for the pin or core side. The cells form one serial path. Serial data enters at the TDI end, and the bit nearest the TDO end is presented on TDO.

An external test access controller supplies the test clock and three one-cycle strobes: capture, shift and update. It also supplies a two-bit mode. The mode selects one of four cases. Normal operation can pass through while the chain samples. The pins can be cut off from the core and driven from the latches, which is external test. The core inputs can be driven from the latches while the pads are released, which is internal test. Values loaded through the chain in normal mode are held in the latches. They reach the pins as soon as external test is selected.

The test reset is asynchronous and active low. Its release is synchronised to the test clock.

Top module: `bsr_chain`

## Requirements
- R1: While trst_n is low, and after it is released until the next update, all shift stages, all update latches and tdo are 0. With mode 01 this makes pin_out, pin_oe and core_in all 0.
- R2: The chain has N_IN+2*N_OUT positions, numbered 0 at the TDI end. Positions 0..N_IN-1 belong to pin_in[i]. Positions N_IN..N_IN+N_OUT-1 belong to the output data bits. Positions N_IN+N_OUT..N_IN+2*N_OUT-1 belong to the output enables.
- R3: On each rising tck edge with shift_dr high and capture_dr low, position 0 takes tdi and every other position p takes the old value of position p-1. tdo shows the last position and changes only on the falling edge of tck.
- R4: On a rising tck edge with capture_dr high, the input cells load pin_in, the data cells load core_out and the enable cells load core_oe. This happens in every mode. Capture takes priority over shift when both strobes are high.
- R5: On a rising tck edge with update_dr high, every update latch copies its cell's shift stage. At all other times the latches hold, so the pins stay stable during capture and shift.
- R6: Mode 01 is external test. pin_out and pin_oe come from the data and enable latches, and core_in comes from the input latches.
- R7: Mode 10 is internal test. core_in comes from the input latches, pin_oe is 0 and pin_out follows core_out.
- R8: Modes 00 and 11 are sample/preload. pin_out follows core_out, pin_oe follows core_oe and core_in follows pin_in, while capture, shift and update still work.
- R9: Latch values loaded by an update in sample/preload mode appear on pin_out and pin_oe as soon as mode changes to 01, with no further update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into chain position 0 |
| tdo | output | 1 | Serial data from the last chain position, changes on the falling edge |
| mode | input | 2 | 00/11 sample/preload, 01 external test, 10 internal test |
| capture_dr | input | 1 | Parallel load strobe |
| shift_dr | input | 1 | Serial shift strobe |
| update_dr | input | 1 | Latch update strobe |
| pin_in | input | N_IN | Values arriving from the input pads |
| core_in | output | N_IN | Input values delivered to the core |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pin_out | output | N_OUT | Output data to the pads |
| pin_oe | output | N_OUT | Output enables to the pads |

## Verification
The hardest case to bring about is capture and shift landing on the same edge. The chain is first cleared with a scan of zeros. Both strobes are then raised together with tdi high and every parallel input high. A shift-only scan then reads the chain out, so the result shows which strobe won. The hold behaviour of the latches also needs care. An update in external test is followed by a full capture and scan with no update, and the pins are compared before the final update moves them. Preload is checked by loading the latches in sample mode and then only changing the mode.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    MODE_SAMPLE = 2'b00,
    MODE_EXTEST = 2'b01,
    MODE_INTEST = 2'b10,
    MODE_SPARE  = 2'b11
  } bsr_mode_e;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic cap_d,
  input  logic ser_in,
  output logic ser_q,
  output logic par_q
);
  logic sr_en;
  logic sr_d;
  logic up_en;
  logic up_d;

  // capture wins over shift
  always_comb begin
    sr_en = capture | shift;
    sr_d  = capture ? cap_d : ser_in;
    up_en = update;
    up_d  = ser_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
    end else if (sr_en) begin
      ser_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
    end else if (up_en) begin
      par_q <= up_d;
    end
  end
endmodule

// File: rtl/bsr_tdo_stage.sv
module bsr_tdo_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  output logic             tdo,
  input  logic [1:0]       mode,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  import bsr_pkg::*;

  localparam int LEN    = N_IN + 2 * N_OUT;
  localparam int OUT_LO = N_IN;
  localparam int OE_LO  = N_IN + N_OUT;

  logic             rst_s;
  logic [LEN-1:0]   cap_vec;
  logic [LEN-1:0]   ser_vec;
  logic [LEN-1:0]   sr_q;
  logic [LEN-1:0]   upd_q;
  logic [N_IN-1:0]  upd_in;
  logic [N_OUT-1:0] upd_out;
  logic [N_OUT-1:0] upd_oe;
  bsr_mode_e        mode_e;

  bsr_rst_sync u_rst (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_s)
  );

  assign cap_vec = {core_oe, core_out, pin_in};
  assign ser_vec = {sr_q[LEN-2:0], tdi};

  for (genvar p = 0; p < LEN; p++) begin : g_cell
    bsr_cell u_cell (
      .clk     (tck),
      .rst_n   (rst_s),
      .capture (capture_dr),
      .shift   (shift_dr),
      .update  (update_dr),
      .cap_d   (cap_vec[p]),
      .ser_in  (ser_vec[p]),
      .ser_q   (sr_q[p]),
      .par_q   (upd_q[p])
    );
  end

  bsr_tdo_stage u_tdo (
    .clk   (tck),
    .rst_n (rst_s),
    .d     (sr_q[LEN-1]),
    .q     (tdo)
  );

  assign upd_in  = upd_q[N_IN-1:0];
  assign upd_out = upd_q[OUT_LO +: N_OUT];
  assign upd_oe  = upd_q[OE_LO +: N_OUT];
  assign mode_e  = bsr_mode_e'(mode);

  always_comb begin
    core_in = pin_in;
    pin_out = core_out;
    pin_oe  = core_oe;
    case (mode_e)
      MODE_EXTEST: begin
        core_in = upd_in;
        pin_out = upd_out;
        pin_oe  = upd_oe;
      end
      MODE_INTEST: begin
        core_in = upd_in;
        pin_oe  = '0;
      end
      default: begin
        core_in = pin_in;
      end
    endcase
  end
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                     tck,
  input logic                     rst_s,
  input logic                     tdi,
  input logic                     tdo,
  input logic [1:0]               mode,
  input logic                     capture_dr,
  input logic                     shift_dr,
  input logic                     update_dr,
  input logic [N_IN-1:0]          pin_in,
  input logic [N_OUT-1:0]         core_out,
  input logic [N_OUT-1:0]         core_oe,
  input logic [N_OUT-1:0]         pin_out,
  input logic [N_OUT-1:0]         pin_oe,
  input logic [N_IN+2*N_OUT-1:0]  sr_q,
  input logic [N_IN+2*N_OUT-1:0]  upd_q
);
  localparam int LEN    = N_IN + 2 * N_OUT;
  localparam int OUT_LO = N_IN;
  localparam int OE_LO  = N_IN + N_OUT;

  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_s)
    capture_dr |=> sr_q == $past({core_oe, core_out, pin_in})); // R4

  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!rst_s)
    (shift_dr && !capture_dr) |=> sr_q == {$past(sr_q[LEN-2:0]), $past(tdi)}); // R3

  AST_TDO_LAST: assert property (@(posedge tck) disable iff (!rst_s)
    tdo == sr_q[LEN-1]); // R3

  AST_UPDATE_LOAD: assert property (@(posedge tck) disable iff (!rst_s)
    update_dr |=> upd_q == $past(sr_q)); // R5

  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!rst_s)
    !update_dr |=> $stable(upd_q)); // R5

  AST_EXTEST_DRIVE: assert property (@(posedge tck) disable iff (!rst_s)
    (update_dr && mode == bsr_pkg::MODE_EXTEST) |=>
      (mode != bsr_pkg::MODE_EXTEST) ||
      (pin_out == $past(sr_q[OUT_LO +: N_OUT]) && pin_oe == $past(sr_q[OE_LO +: N_OUT]))); // R6
endmodule

bind bsr_chain bsr_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .tck        (tck),
  .rst_s      (rst_s),
  .tdi        (tdi),
  .tdo        (tdo),
  .mode       (mode),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .pin_in     (pin_in),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .sr_q       (sr_q),
  .upd_q      (upd_q)
);

// File: tb/bsr_chain_test.sv
module bsr_chain_test;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int L  = NI + 2 * NO;

  logic          tck;
  logic          trst_n;
  logic          tdi;
  logic          tdo;
  logic [1:0]    mode;
  logic          capture_dr;
  logic          shift_dr;
  logic          update_dr;
  logic [NI-1:0] pin_in;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] core_oe;
  logic [NO-1:0] pin_out;
  logic [NO-1:0] pin_oe;

  int n_chk;
  int n_bad;
  int cycles;
  bit done;

  bsr_chain #(.N_IN(NI), .N_OUT(NO)) uut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo), .mode(mode),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
    .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial tck = 1'b0;
  always #2 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // full scan: optional capture, then L shifts; din[p] ends at position p,
  // dout[p] is what position p held before shifting
  task automatic scan(input bit do_cap, input logic [L-1:0] din, output logic [L-1:0] dout);
    logic last;
    dout = '0;
    if (do_cap) begin
      capture_dr = 1'b1;
      @(posedge tck); #1;
      capture_dr = 1'b0;
    end
    shift_dr = 1'b1;
    for (int k = 0; k < L; k++) begin
      @(negedge tck); #1;
      dout[L-1-k] = tdo;
      last = tdo;
      tdi = din[L-1-k];
      @(posedge tck); #1;
      chk("R3 tdo holds across rising edge", {31'b0, tdo}, {31'b0, last});
    end
    shift_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0;
  endtask

  initial begin
    cycles = 0;
    while (!done) begin
      @(posedge tck);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [L-1:0] dout;
    logic [L-1:0] din;
    logic [L-1:0] expv;
    logic [L-1:0] a_vec;
    logic [L-1:0] b_vec;
    n_chk = 0; n_bad = 0; done = 1'b0;
    trst_n = 1'b0; tdi = 1'b0; mode = 2'b01;
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    pin_in = '1; core_out = '1; core_oe = '1;
    repeat (3) @(posedge tck);
    #1;
    chk("R1 tdo in reset", {31'b0, tdo}, 32'd0);
    chk("R1 pin_out in reset", {30'b0, pin_out}, 32'd0);
    chk("R1 pin_oe in reset", {30'b0, pin_oe}, 32'd0);
    chk("R1 core_in in reset", {29'b0, core_in}, 32'd0);
    trst_n = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    scan(1'b0, '0, dout);
    chk("R1 shift stages after reset", {25'b0, dout}, 32'd0);

    // sweep every parallel input combination, R2 R4 R6 R7 R8
    for (int c = 0; c < 128; c++) begin
      pin_in   = c[2:0];
      core_out = c[4:3];
      core_oe  = c[6:5];
      mode     = 2'((c >> 2) & 3);
      din      = 7'((c * 37 + 11) & 8'h7f);
      expv     = {core_oe, core_out, pin_in};
      scan(1'b1, din, dout);
      chk("R4 R2 captured chain", {25'b0, dout}, {25'b0, expv});
      do_update();
      for (int m = 0; m < 4; m++) begin
        mode = 2'(m);
        #1;
        if (m == 1) begin
          chk("R6 pin_out", {30'b0, pin_out}, {30'b0, din[4:3]});
          chk("R6 pin_oe", {30'b0, pin_oe}, {30'b0, din[6:5]});
          chk("R6 core_in", {29'b0, core_in}, {29'b0, din[2:0]});
        end else if (m == 2) begin
          chk("R7 pin_out", {30'b0, pin_out}, {30'b0, core_out});
          chk("R7 pin_oe", {30'b0, pin_oe}, 32'd0);
          chk("R7 core_in", {29'b0, core_in}, {29'b0, din[2:0]});
        end else begin
          chk("R8 pin_out", {30'b0, pin_out}, {30'b0, core_out});
          chk("R8 pin_oe", {30'b0, pin_oe}, {30'b0, core_oe});
          chk("R8 core_in", {29'b0, core_in}, {29'b0, pin_in});
        end
      end
    end

    // capture beats shift, R4
    scan(1'b0, '0, dout);
    pin_in = '1; core_out = '1; core_oe = '1; tdi = 1'b1;
    capture_dr = 1'b1; shift_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0; shift_dr = 1'b0;
    scan(1'b0, '0, dout);
    chk("R4 capture priority over shift", {25'b0, dout}, 32'h7f);

    // latch hold while scanning in external test, R5
    mode = 2'b01;
    a_vec = 7'b1011010;
    b_vec = 7'b0100101;
    scan(1'b1, a_vec, dout);
    do_update();
    scan(1'b1, b_vec, dout);
    #1;
    chk("R5 pin_out held without update", {30'b0, pin_out}, {30'b0, a_vec[4:3]});
    chk("R5 pin_oe held without update", {30'b0, pin_oe}, {30'b0, a_vec[6:5]});
    do_update();
    chk("R5 pin_out after update", {30'b0, pin_out}, {30'b0, b_vec[4:3]});
    chk("R5 pin_oe after update", {30'b0, pin_oe}, {30'b0, b_vec[6:5]});

    // preload in sample mode then switch, R9
    mode = 2'b00;
    core_out = 2'b00; core_oe = 2'b00;
    scan(1'b1, 7'b1110001, dout);
    do_update();
    chk("R9 sample keeps core path", {30'b0, pin_oe}, 32'd0);
    mode = 2'b01;
    #1;
    chk("R9 preloaded pin_out", {30'b0, pin_out}, 32'd2);
    chk("R9 preloaded pin_oe", {30'b0, pin_oe}, 32'd3);
    chk("R9 preloaded core_in", {29'b0, core_in}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule